// File: doc/BRIEF.md
# NOR Flash Array Controller

This block models an on-chip NOR flash array together with the small controller that guards it. Software reaches it through three word-wide ports. A control register port holds a mode register, a ready indicator and three erase commands. A data port reads and programs the flash array one 32-bit word at a time. A third port reads and writes a small bank of user configuration words.

Programming follows NOR rules: a write can only clear bits, so the stored word becomes the old word ANDed with the new data. Two mode bits guard the array. Programming is refused unless the write-enable bit is set. Page erase and whole-array erase are refused unless the erase-enable bit is set. Erasing the configuration bank needs no enable.

Every command finishes in the clock edge that accepts it. Read data appears one cycle after the request. Any refused or undefined access raises a one-cycle error pulse in that same following cycle. All addresses are word indices. The page erase command takes a byte address in its data.

Top module: `nor_flash_ctrl`

## Requirements
- R1: After reset the mode register reads 0, every configuration word reads 0xFFFFFFFF and the error output is low. Reset leaves the flash array contents unchanged.
- R2: The mode register is at word offset 1. Bit 0 is write-enable and bit 1 is erase-enable. A write keeps only bits [1:0], and the register reads back that masked value. Word offset 0 always reads 1, meaning ready.
- R3: While write-enable is set, a flash write stores the old word ANDed with the written data.
- R4: While write-enable is clear, a flash write leaves the array unchanged and raises the error pulse.
- R5: A write to the page erase register at word offset 2 or word offset 3 clears the in-page bits of the byte address in the data. If erase-enable is set, every word of the addressed page becomes 0xFFFFFFFF. Other pages keep their contents.
- R6: A page erase whose page start is above the flash size minus the page size changes nothing and raises no error. A page erase while erase-enable is clear changes nothing and raises the error pulse.
- R7: Writing the erase code 1 to word offset 4 with erase-enable set sets the whole array and all configuration words to 0xFFFFFFFF. With erase-enable clear it changes nothing and raises the error pulse. Any other value is ignored and raises no error.
- R8: Writing the erase code 1 to word offset 5 sets all configuration words to 0xFFFFFFFF, whatever the mode bits are. Any other value is ignored.
- R9: Configuration words store and return written values as they are.
- R10: A register read at any offset other than 0 or 1 returns 0 and raises the error pulse. A register write at offset 0 or above 5 is ignored and raises the error pulse.
- R11: Read data on every port, and the error pulse, appear in the cycle after the request.
- R12: An erase in the same cycle as a flash write or a configuration write to an affected word wins, so the word reads 0xFFFFFFFF afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_req | input | 1 | Control register access strobe |
| reg_we | input | 1 | Control access is a write |
| reg_addr | input | 6 | Control register word offset |
| reg_wdata | input | 32 | Control write data |
| reg_rdata | output | 32 | Control read data, one cycle after request |
| fl_req | input | 1 | Flash array access strobe |
| fl_we | input | 1 | Flash access is a program |
| fl_addr | input | FWI_W | Flash word index |
| fl_wdata | input | 32 | Flash program data |
| fl_rdata | output | 32 | Flash read data, one cycle after request |
| cw_req | input | 1 | Configuration word access strobe |
| cw_we | input | 1 | Configuration access is a write |
| cw_addr | input | CWI_W | Configuration word index |
| cw_wdata | input | 32 | Configuration write data |
| cw_rdata | output | 32 | Configuration read data, one cycle after request |
| err_pulse | output | 1 | One-cycle error indication for a refused or undefined access |

## Verification
The bench tests the cases where a guard can leak. It programs a word twice to prove the AND behaviour; a design that simply overwrites would return the second value. It issues page erases with in-page offset bits set, with a start beyond the last page, and with erase-enable clear; a wrong range check or a missing offset mask would wipe the wrong page. It issues erase-all with a non-code value, and a configuration erase with both enables clear. It issues an erase in the same cycle as a program to the same page, where the wrong priority leaves programmed bits behind. A reset in the middle of the run shows that the flash survives reset while the mode and configuration state do not.

// File: rtl/nfc_pkg.sv
// Shared constants and types for the NOR flash controller.
// Assumes word-granular addressing on every port.
package nfc_pkg;
    localparam int          REG_OW     = 6;
    localparam logic [31:0] ERASE_CODE = 32'd1;

    // Control register word offsets; the decode depends on these values.
    localparam logic [REG_OW-1:0] OFS_READY  = 6'd0;
    localparam logic [REG_OW-1:0] OFS_MODE   = 6'd1;
    localparam logic [REG_OW-1:0] OFS_PG_A   = 6'd2;
    localparam logic [REG_OW-1:0] OFS_PG_B   = 6'd3;
    localparam logic [REG_OW-1:0] OFS_ALL    = 6'd4;
    localparam logic [REG_OW-1:0] OFS_CFGCLR = 6'd5;

    // Mode register: bit 1 erase-enable, bit 0 write-enable.
    typedef struct packed {
        logic een;
        logic wen;
    } mode_t;
endpackage

// File: rtl/nfc_regs.sv
// Control register decode for the NOR flash controller.
// Holds the mode register, produces single-cycle erase strobes and
// the registered read data and error pulse. Assumes PAGE_BYTES and
// NUM_PAGES are powers of two and NUM_PAGES >= 2.
module nfc_regs
    import nfc_pkg::*;
#(
    parameter int PAGE_BYTES = 1024,
    parameter int NUM_PAGES  = 4,
    localparam int PG_W      = $clog2(NUM_PAGES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_OW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    input  logic              fl_wr_denied,
    output logic [31:0]       reg_rdata,
    output logic              err_pulse,
    output mode_t             mode,
    output logic              pg_erase,
    output logic [PG_W-1:0]   pg_idx,
    output logic              all_erase,
    output logic              cfg_erase
);
    localparam int          PG_SH      = $clog2(PAGE_BYTES);
    localparam logic [31:0] LAST_START = 32'(PAGE_BYTES * (NUM_PAGES - 1));

    logic        wr, rd, is_pg, is_code, rd_undef, wr_undef, cmd_err;
    logic [31:0] pg_start;

    // Decode the access and form the erase strobes.
    always_comb begin
        wr        = reg_req & reg_we;
        rd        = reg_req & ~reg_we;
        is_pg     = (reg_addr == OFS_PG_A) || (reg_addr == OFS_PG_B);
        is_code   = (reg_wdata == ERASE_CODE);
        pg_start  = reg_wdata & ~32'(PAGE_BYTES - 1);
        pg_idx    = pg_start[PG_SH +: PG_W];
        pg_erase  = wr & is_pg & mode.een & (pg_start <= LAST_START);
        all_erase = wr & (reg_addr == OFS_ALL) & is_code & mode.een;
        cfg_erase = wr & (reg_addr == OFS_CFGCLR) & is_code;
        rd_undef  = rd & (reg_addr != OFS_READY) & (reg_addr != OFS_MODE);
        wr_undef  = wr & ((reg_addr == OFS_READY) || (reg_addr > OFS_CFGCLR));
        cmd_err   = wr & ~mode.een & (is_pg | ((reg_addr == OFS_ALL) & is_code));
    end

    // Mode register keeps only its two defined bits.
    always_ff @(posedge clk) begin
        if (!rst_n)                        mode <= '0;
        else if (wr && reg_addr == OFS_MODE) mode <= mode_t'(reg_wdata[1:0]);
    end

    // Registered read data and error pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata <= '0;
            err_pulse <= 1'b0;
        end else begin
            err_pulse <= rd_undef | wr_undef | cmd_err | fl_wr_denied;
            if (rd) begin
                if (reg_addr == OFS_READY)     reg_rdata <= 32'd1;
                else if (reg_addr == OFS_MODE) reg_rdata <= {30'd0, mode};
                else                           reg_rdata <= '0;
            end
        end
    end
endmodule

// File: rtl/nfc_array.sv
// Flash word storage with NOR programming and parallel erase.
// Programming ANDs data into the stored word; an erase in the same
// cycle takes priority. Contents are not touched by reset.
module nfc_array #(
    parameter int PAGE_BYTES = 1024,
    parameter int NUM_PAGES  = 4,
    localparam int WORDS      = PAGE_BYTES / 4 * NUM_PAGES,
    localparam int PAGE_WORDS = PAGE_BYTES / 4,
    localparam int WI_W       = $clog2(WORDS),
    localparam int PG_W       = $clog2(NUM_PAGES)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fl_req,
    input  logic            fl_we,
    input  logic [WI_W-1:0] fl_addr,
    input  logic [31:0]     fl_wdata,
    input  logic            wen,
    input  logic            pg_erase,
    input  logic [PG_W-1:0] pg_idx,
    input  logic            all_erase,
    output logic [31:0]     fl_rdata,
    output logic            wr_denied
);
    logic [31:0] mem [WORDS];

    // A program request without write-enable is refused.
    always_comb wr_denied = fl_req & fl_we & ~wen;

    // Storage update: NOR program first, then erase overrides.
    always_ff @(posedge clk) begin
        if (fl_req && fl_we && wen) mem[fl_addr] <= mem[fl_addr] & fl_wdata;
        for (int i = 0; i < WORDS; i++) begin
            if (all_erase || (pg_erase && (i / PAGE_WORDS) == int'(pg_idx)))
                mem[i] <= '1;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)                 fl_rdata <= '0;
        else if (fl_req && !fl_we)  fl_rdata <= mem[fl_addr];
    end
endmodule

// File: rtl/nfc_cfgmem.sv
// User configuration word bank. Plain read/write storage that resets
// to all ones and is wiped to all ones by an erase strobe, which
// beats a write in the same cycle.
module nfc_cfgmem #(
    parameter int CFG_WORDS = 64,
    localparam int CI_W     = $clog2(CFG_WORDS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cw_req,
    input  logic            cw_we,
    input  logic [CI_W-1:0] cw_addr,
    input  logic [31:0]     cw_wdata,
    input  logic            wipe,
    output logic [31:0]     cw_rdata
);
    logic [31:0] word_q [CFG_WORDS];

    for (genvar g = 0; g < CFG_WORDS; g++) begin : g_word
        // One configuration word: reset/wipe to ones, else write.
        always_ff @(posedge clk) begin
            if (!rst_n || wipe)                           word_q[g] <= '1;
            else if (cw_req && cw_we && cw_addr == CI_W'(g)) word_q[g] <= cw_wdata;
        end
    end

    // Registered read port.
    always_ff @(posedge clk) begin
        if (!rst_n)                cw_rdata <= '0;
        else if (cw_req && !cw_we) cw_rdata <= word_q[cw_addr];
    end
endmodule

// File: rtl/nor_flash_ctrl.sv
// NOR flash controller top: control registers, flash array and
// configuration bank. Every command completes in one clock; reads and
// the error pulse are registered with one cycle of latency.
module nor_flash_ctrl
    import nfc_pkg::*;
#(
    parameter int PAGE_BYTES = 1024,
    parameter int NUM_PAGES  = 4,
    parameter int CFG_WORDS  = 64,
    localparam int FWI_W     = $clog2(PAGE_BYTES / 4 * NUM_PAGES),
    localparam int CWI_W     = $clog2(CFG_WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_we,
    input  logic [REG_OW-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              fl_req,
    input  logic              fl_we,
    input  logic [FWI_W-1:0]  fl_addr,
    input  logic [31:0]       fl_wdata,
    output logic [31:0]       fl_rdata,
    input  logic              cw_req,
    input  logic              cw_we,
    input  logic [CWI_W-1:0]  cw_addr,
    input  logic [31:0]       cw_wdata,
    output logic [31:0]       cw_rdata,
    output logic              err_pulse
);
    localparam int PG_W = $clog2(NUM_PAGES);

    mode_t           mode_w;
    logic            wen_w, pg_erase_w, all_erase_w, cfg_erase_w, denied_w;
    logic [PG_W-1:0] pg_idx_w;

    // Write-enable and configuration wipe taps.
    assign wen_w = mode_w.wen;

    nfc_regs #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_regs (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .fl_wr_denied(denied_w),
        .reg_rdata(reg_rdata), .err_pulse(err_pulse), .mode(mode_w),
        .pg_erase(pg_erase_w), .pg_idx(pg_idx_w), .all_erase(all_erase_w),
        .cfg_erase(cfg_erase_w)
    );

    nfc_array #(.PAGE_BYTES(PAGE_BYTES), .NUM_PAGES(NUM_PAGES)) u_array (
        .clk(clk), .rst_n(rst_n), .fl_req(fl_req), .fl_we(fl_we),
        .fl_addr(fl_addr), .fl_wdata(fl_wdata), .wen(wen_w),
        .pg_erase(pg_erase_w), .pg_idx(pg_idx_w), .all_erase(all_erase_w),
        .fl_rdata(fl_rdata), .wr_denied(denied_w)
    );

    nfc_cfgmem #(.CFG_WORDS(CFG_WORDS)) u_cfg (
        .clk(clk), .rst_n(rst_n), .cw_req(cw_req), .cw_we(cw_we),
        .cw_addr(cw_addr), .cw_wdata(cw_wdata),
        .wipe(cfg_erase_w | all_erase_w), .cw_rdata(cw_rdata)
    );
endmodule

// File: rtl/nfc_checker.sv
// Protocol checks for nor_flash_ctrl, attached by bind below.
module nfc_checker
    import nfc_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              reg_req,
    input logic              reg_we,
    input logic [REG_OW-1:0] reg_addr,
    input logic [31:0]       reg_wdata,
    input logic [31:0]       reg_rdata,
    input logic              fl_req,
    input logic              fl_we,
    input logic              cw_req,
    input logic              cw_we,
    input logic [31:0]       cw_rdata,
    input logic              err_pulse,
    input logic              wen
);
    logic rd, wr, known_rd, known_wr;
    // Access classification as seen at the ports.
    always_comb begin
        rd       = reg_req & ~reg_we;
        wr       = reg_req & reg_we;
        known_rd = (reg_addr == OFS_READY) || (reg_addr == OFS_MODE);
        known_wr = (reg_addr >= OFS_MODE) && (reg_addr <= OFS_CFGCLR);
    end

    p_ready_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd && reg_addr == OFS_READY |=> reg_rdata == 32'd1);
    p_mode_mask_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rd && reg_addr == OFS_MODE |=> reg_rdata[31:2] == 30'd0);
    p_undef_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
        rd && !known_rd |=> reg_rdata == 32'd0 && err_pulse);
    p_undef_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr && !known_wr |=> err_pulse);
    p_denied_prog_r4: assert property (@(posedge clk) disable iff (!rst_n)
        fl_req && fl_we && !wen |=> err_pulse);
    p_cfg_wipe_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cw_req && !cw_we && $past(wr && reg_addr == OFS_CFGCLR && reg_wdata == ERASE_CODE)
        |=> cw_rdata == 32'hFFFF_FFFF);
endmodule

bind nor_flash_ctrl nfc_checker u_chk (
    .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .fl_req(fl_req), .fl_we(fl_we), .cw_req(cw_req), .cw_we(cw_we),
    .cw_rdata(cw_rdata), .err_pulse(err_pulse), .wen(wen_w)
);

// File: tb/nor_flash_ctrl_tb_top.sv
// Scoreboard bench: driver tasks update a requirement-level model and
// queue expected results; a monitor compares them after each edge.
module nor_flash_ctrl_tb_top;
    localparam int PB  = 32;
    localparam int NP  = 4;
    localparam int CW  = 8;
    localparam int FB  = PB * NP;
    localparam int FW  = FB / 4;
    localparam int PW  = PB / 4;
    localparam int FAW = $clog2(FW);
    localparam int CAW = $clog2(CW);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_req = 0, reg_we = 0;
    logic [5:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0, reg_rdata;
    logic fl_req = 0, fl_we = 0;
    logic [FAW-1:0] fl_addr = '0;
    logic [31:0] fl_wdata = '0, fl_rdata;
    logic cw_req = 0, cw_we = 0;
    logic [CAW-1:0] cw_addr = '0;
    logic [31:0] cw_wdata = '0, cw_rdata;
    logic err_pulse;

    always #5 clk = ~clk;

    nor_flash_ctrl #(.PAGE_BYTES(PB), .NUM_PAGES(NP), .CFG_WORDS(CW)) dut_i (
        .clk(clk), .rst_n(rst_n), .reg_req(reg_req), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .fl_req(fl_req), .fl_we(fl_we), .fl_addr(fl_addr), .fl_wdata(fl_wdata),
        .fl_rdata(fl_rdata), .cw_req(cw_req), .cw_we(cw_we), .cw_addr(cw_addr),
        .cw_wdata(cw_wdata), .cw_rdata(cw_rdata), .err_pulse(err_pulse)
    );

    typedef struct {
        int          due;
        int          kind;   // 0 reg, 1 flash, 2 cfg, 3 error
        logic [31:0] exp;
        string       tag;
    } item_t;

    item_t       sb[$];
    int          cyc = 0;
    int          total = 0;
    int          bad = 0;
    logic [31:0] fm [FW];
    logic [31:0] cm [CW];
    logic [1:0]  mode_m = 2'b00;

    // Monitor: compare due items shortly after each rising edge.
    initial forever begin
        @(posedge clk);
        #2;
        cyc++;
        while (sb.size() > 0 && sb[0].due <= cyc) begin : pop_blk
            item_t       it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.kind)
                0: act = reg_rdata;
                1: act = fl_rdata;
                2: act = cw_rdata;
                default: act = {31'd0, err_pulse};
            endcase
            total++;
            if (act !== it.exp) begin
                bad++;
                $display("FAIL %s kind=%0d actual=%h expected=%h", it.tag, it.kind, act, it.exp);
            end
        end
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (20000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    task automatic push(int kind, logic [31:0] exp, string tag);
        sb.push_back('{cyc + 1, kind, exp, tag});
    endtask

    task automatic idle();
        reg_req = 0; reg_we = 0; fl_req = 0; fl_we = 0; cw_req = 0; cw_we = 0;
    endtask

    task automatic finish_cycle();
        @(negedge clk);
        idle();
    endtask

    // Model of a register write's effect; returns expected error.
    function automatic logic model_reg_wr(logic [5:0] a, logic [31:0] d);
        logic        e = 1'b0;
        logic [31:0] ps;
        case (a)
            6'd1: mode_m = d[1:0];
            6'd2, 6'd3: begin
                ps = d & ~32'(PB - 1);
                if (!mode_m[1]) e = 1'b1;
                else if (ps <= 32'(FB - PB))
                    for (int i = 0; i < PW; i++) fm[int'(ps) / 4 + i] = '1;
            end
            6'd4: if (d == 32'd1) begin
                if (mode_m[1]) begin
                    for (int i = 0; i < FW; i++) fm[i] = '1;
                    for (int i = 0; i < CW; i++) cm[i] = '1;
                end else e = 1'b1;
            end
            6'd5: if (d == 32'd1) for (int i = 0; i < CW; i++) cm[i] = '1;
            default: e = 1'b1;
        endcase
        return e;
    endfunction

    task automatic reg_wr(logic [5:0] a, logic [31:0] d, string tag);
        reg_req = 1; reg_we = 1; reg_addr = a; reg_wdata = d;
        push(3, {31'd0, model_reg_wr(a, d)}, tag);
        finish_cycle();
    endtask

    task automatic reg_rd(logic [5:0] a, logic [31:0] exp, string tag);
        reg_req = 1; reg_we = 0; reg_addr = a;
        push(0, exp, tag);
        push(3, {31'd0, !(a == 6'd0 || a == 6'd1)}, tag);
        finish_cycle();
    endtask

    task automatic fl_wr(int i, logic [31:0] d, string tag);
        fl_req = 1; fl_we = 1; fl_addr = FAW'(i); fl_wdata = d;
        if (mode_m[0]) fm[i] = fm[i] & d;
        push(3, {31'd0, !mode_m[0]}, tag);
        finish_cycle();
    endtask

    task automatic fl_rd(int i, string tag);
        fl_req = 1; fl_we = 0; fl_addr = FAW'(i);
        push(1, fm[i], tag);
        push(3, 32'd0, tag);
        finish_cycle();
    endtask

    task automatic cw_wr(int i, logic [31:0] d, string tag);
        cw_req = 1; cw_we = 1; cw_addr = CAW'(i); cw_wdata = d;
        cm[i] = d;
        push(3, 32'd0, tag);
        finish_cycle();
    endtask

    task automatic cw_rd(int i, string tag);
        cw_req = 1; cw_we = 0; cw_addr = CAW'(i);
        push(1 + 1, cm[i], tag);
        push(3, 32'd0, tag);
        finish_cycle();
    endtask

    task automatic do_reset();
        rst_n = 0;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1;
        mode_m = 2'b00;
        for (int i = 0; i < CW; i++) cm[i] = '1;
    endtask

    initial begin
        do_reset();
        // R1: reset state
        push(3, 32'd0, "R1 idle error low");
        @(negedge clk);
        reg_rd(6'd1, 32'd0, "R1 mode after reset");
        for (int i = 0; i < CW; i++) cw_rd(i, "R1 cfg word after reset");
        // R2: ready and mode masking
        reg_rd(6'd0, 32'd1, "R2 ready");
        reg_wr(6'd1, 32'hFFFF_FFFC, "R2 mode write");
        reg_rd(6'd1, 32'd0, "R2 upper bits dropped");
        reg_wr(6'd1, 32'hFFFF_FFFF, "R2 mode write all");
        reg_rd(6'd1, 32'd3, "R2 masked readback");
        reg_wr(6'd1, 32'd2, "R2 erase-enable only");
        // R7: erase all initialises the array
        reg_wr(6'd4, 32'd1, "R7 erase all");
        for (int i = 0; i < FW; i += 5) fl_rd(i, "R7 array ones");
        // R4: refused program
        fl_wr(3, 32'h0, "R4 refused write");
        fl_rd(3, "R4 unchanged");
        // R3: NOR program
        reg_wr(6'd1, 32'd3, "R3 enable both");
        fl_wr(5, 32'hF0F0_1234, "R3 first program");
        fl_rd(5, "R3 first value");
        fl_wr(5, 32'h0FFF_FF00, "R3 second program");
        fl_rd(5, "R3 AND result");
        fl_wr(PW + 2, 32'h1111_2222, "R3 page1 word");
        fl_wr(2 * PW + 1, 32'h3333_4444, "R3 page2 word");
        fl_wr(3 * PW + 7, 32'h5555_6666, "R3 page3 word");
        fl_rd(FW - 1, "R11 back-to-back read");
        fl_rd(3 * PW + 7, "R11 back-to-back read");
        // R9: config words
        cw_wr(2, 32'hA5A5_0001, "R9 cfg write");
        cw_wr(7, 32'h0000_0000, "R9 cfg write zero");
        cw_rd(2, "R9 cfg read");
        cw_rd(7, "R9 cfg read");
        // R5: page erase through both registers, offset bits dropped
        reg_wr(6'd2, 32'(PB + 20), "R5 erase page1 via A");
        fl_rd(PW + 2, "R5 page1 erased");
        fl_rd(5, "R5 page0 kept");
        fl_rd(2 * PW + 1, "R5 page2 kept");
        reg_wr(6'd3, 32'(2 * PB + 3), "R5 erase page2 via B");
        fl_rd(2 * PW + 1, "R5 page2 erased");
        fl_rd(3 * PW + 7, "R5 page3 kept");
        // R6: out of range and disabled page erase
        reg_wr(6'd2, 32'(FB), "R6 beyond last page");
        fl_rd(3 * PW + 7, "R6 no change beyond range");
        fl_rd(5, "R6 no change beyond range");
        reg_wr(6'd1, 32'd1, "R6 write-enable only");
        reg_wr(6'd2, 32'd0, "R6 disabled page erase");
        fl_rd(5, "R6 page0 kept when disabled");
        // R7: disabled and wrong-code erase all
        reg_wr(6'd4, 32'd1, "R7 disabled erase all");
        fl_rd(5, "R7 unchanged when disabled");
        cw_rd(2, "R7 cfg unchanged when disabled");
        reg_wr(6'd1, 32'd2, "R7 erase-enable");
        reg_wr(6'd4, 32'd2, "R7 wrong code ignored");
        fl_rd(3 * PW + 7, "R7 unchanged by wrong code");
        // R8: config erase without enables
        reg_wr(6'd1, 32'd0, "R8 disable all");
        reg_wr(6'd5, 32'd5, "R8 wrong code");
        cw_rd(2, "R8 cfg kept on wrong code");
        reg_wr(6'd5, 32'd1, "R8 cfg erase");
        cw_rd(2, "R8 cfg ones");
        cw_rd(7, "R8 cfg ones");
        // R10: undefined offsets
        reg_rd(6'd15, 32'd0, "R10 undefined read");
        reg_rd(6'd4, 32'd0, "R10 command read");
        reg_wr(6'd15, 32'd3, "R10 undefined write");
        reg_wr(6'd0, 32'd3, "R10 ready write");
        reg_rd(6'd1, 32'd0, "R10 mode unaffected");
        // R12: erase beats a same-cycle program / cfg write
        reg_wr(6'd1, 32'd3, "R12 enable both");
        fl_wr(PW + 4, 32'h0, "R12 pre-program");
        reg_req = 1; reg_we = 1; reg_addr = 6'd2; reg_wdata = 32'(PB);
        fl_req = 1; fl_we = 1; fl_addr = FAW'(PW + 4); fl_wdata = 32'h0;
        for (int i = 0; i < PW; i++) fm[PW + i] = '1;
        push(3, 32'd0, "R12 concurrent erase and program");
        finish_cycle();
        fl_rd(PW + 4, "R12 erase wins over program");
        reg_req = 1; reg_we = 1; reg_addr = 6'd5; reg_wdata = 32'd1;
        cw_req = 1; cw_we = 1; cw_addr = CAW'(3); cw_wdata = 32'h0;
        for (int i = 0; i < CW; i++) cm[i] = '1;
        push(3, 32'd0, "R12 concurrent cfg erase and write");
        finish_cycle();
        cw_rd(3, "R12 cfg erase wins");
        // R1: reset keeps flash, clears mode and cfg
        fl_wr(6, 32'h0000_FFFF, "R1 program before reset");
        cw_wr(1, 32'h1234_5678, "R1 cfg before reset");
        @(negedge clk);
        @(negedge clk);
        do_reset();
        reg_rd(6'd1, 32'd0, "R1 mode cleared");
        fl_rd(6, "R1 flash kept over reset");
        fl_rd(5, "R1 flash kept over reset");
        cw_rd(1, "R1 cfg reset to ones");
        repeat (3) @(negedge clk);
        if (sb.size() != 0) begin
            total++;
            bad++;
            $display("FAIL scoreboard not drained actual=%0d expected=0", sb.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule